// File: doc/BRIEF.md
# Gated Auto-Reload Timer/Counter

This block is one timer/counter channel with three counting layouts taken from a small register set: a 13-bit counter made of a 5-bit prescale part and an 8-bit upper byte, a full 16-bit counter, and an 8-bit counter that reloads from a holding byte each time it wraps. Each increment comes from one of two sources. In counter mode it is a falling edge on an external pin. In timer mode it is every system clock or a prescaled clock-enable pulse.

Counting is allowed only while the run bit is set. The gate enable can also make it depend on an external gate level, and a polarity bit inverts that level first. A wrap of the active layout sets a sticky overflow flag. When the interrupt enable is set, the flag drives an interrupt request. Software sets up the channel through a byte-wide write port. It reads the two count bytes back on dedicated outputs.

Top module: `gated_reload_timer`

## Requirements
- R1: After asynchronous reset, the count bytes, the configuration, the run bit and the flag are all zero, so `lo_o`, `hi_o`, `ovf_o` and `irq_o` read 0.
- R2: Mode code 00 (mode register bits [1:0]) is the 13-bit layout. The count is {`hi_o`, `lo_o`[4:0]}, bits `lo_o`[7:5] never change while counting, and a step from 0x1FFF wraps to 0 and raises the flag.
- R3: Mode code 01 is the 16-bit layout. {`hi_o`,`lo_o`} steps by one, and a step from 0xFFFF wraps to 0 and raises the flag.
- R4: Mode code 10 is the 8-bit reload layout. A step from `lo_o`=0xFF loads `lo_o` from `hi_o` and raises the flag in the same clock. `hi_o` is never changed by counting.
- R5: A step happens only when the run bit (control register bit 4) is 1 and either the gate enable (mode register bit 3) is 0 or `gate_i` XOR the gate polarity bit (mode register bit 5) is 1.
- R6: The flag is control register bit 5. An overflow sets it. It stays set until `ack_i` pulses or software writes a 0 to bit 5, and it sets if software writes a 1 to bit 5. An overflow in the same cycle as either clear wins.
- R7: When mode register bit 2 is 1, the step source is a falling edge of `cnt_pin_i` after a two-flop synchronizer, with at most one step per clock. When bit 2 is 0, mode register bit 4 selects a step every clock (1) or on `presc_en_i` (0).
- R8: A write to the low byte (select 0) or the high byte (select 1) shows on the outputs after the next clock edge. It replaces any step in that cycle: neither count byte advances.
- R9: `irq_o` is 1 exactly while the flag is set and the interrupt enable (mode register bit 6) is 1.
- R10: Mode code 11 holds both count bytes and never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_en_i | input | 1 | Prescaled clock enable, one cycle wide |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| gate_i | input | 1 | External gate level, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 low byte, 1 high byte, 2 mode, 3 control |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| lo_o | output | 8 | Low count byte |
| hi_o | output | 8 | High count byte or reload value |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these rules: the reload step copies the high byte into the low byte, the high byte stays unchanged in reload and hold modes, and the count is frozen whenever no step is enabled. They also check that an overflow event always leaves the flag set, that a low-byte write lands one clock later, and that the interrupt never asserts without the flag. Only the bench scenarios can show the exact wrap points of the 13-bit and 16-bit layouts, the gate polarity combinations, the synchronizer latency of pin edges, the prescaled step rate, and the priority of an overflow over a same-cycle flag clear.

// File: rtl/grt_pkg.sv
package grt_pkg;
  typedef enum logic [1:0] {
    MODE_13   = 2'b00,
    MODE_16   = 2'b01,
    MODE_RLD  = 2'b10,
    MODE_HOLD = 2'b11
  } grt_mode_e;

  // mode register image, MSB first: bit6 .. bit0
  typedef struct packed {
    logic      irq_en;
    logic      gate_pol;
    logic      clk_sel;
    logic      gate_en;
    logic      cnt_sel;
    grt_mode_e mode;
  } grt_cfg_t;

  localparam int CFG_W = $bits(grt_cfg_t);

  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int RUN_BIT  = 4;
  localparam int FLAG_BIT = 5;
endpackage

// File: rtl/grt_regs.sv
module grt_regs
  import grt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ovf_evt_i,
  input  logic              ack_i,
  output grt_cfg_t          cfg_o,
  output logic              run_o,
  output logic              flag_o
);
  logic wr_mode, wr_ctrl;
  assign wr_mode = wr_en_i && (wr_sel_i == SEL_MODE);
  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_mode) begin
      cfg_o <= grt_cfg_t'(wr_data_i[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      flag_o <= 1'b0;
    end else if (wr_ctrl) begin
      run_o  <= wr_data_i[RUN_BIT];
      flag_o <= wr_data_i[FLAG_BIT] | ovf_evt_i;  // overflow beats a clear
    end else if (ovf_evt_i) begin
      flag_o <= 1'b1;
    end else if (ack_i) begin
      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/grt_src.sv
module grt_src
  import grt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cnt_pin_i,
  input  logic     presc_en_i,
  input  logic     gate_i,
  input  grt_cfg_t cfg_i,
  input  logic     run_i,
  output logic     inc_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= cnt_pin_i;
  end

  for (genvar g = 1; g < SH_W; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b0;
      else         sh_q[g] <= sh_q[g-1];
    end
  end

  logic pin_fall, tick, gate_ok;
  assign pin_fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];
  assign tick     = cfg_i.cnt_sel ? pin_fall : (cfg_i.clk_sel | presc_en_i);
  assign gate_ok  = ~cfg_i.gate_en | (gate_i ^ cfg_i.gate_pol);
  assign inc_o    = run_i & gate_ok & tick;
endmodule

// File: rtl/grt_count.sv
module grt_count
  import grt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LOW_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  grt_mode_e         mode_i,
  input  logic              inc_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_evt_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [LOW_W-1:0]  LOW_ONE  = 1;
  localparam logic [BYTE_W-1:0] BYTE_ONE = 1;
  localparam logic [WORD_W-1:0] WORD_ONE = 1;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              wr_lo, wr_hi, step, ovf;

  assign wr_lo = wr_en_i && (wr_sel_i == SEL_LO);
  assign wr_hi = wr_en_i && (wr_sel_i == SEL_HI);
  assign step  = inc_i && !wr_lo && !wr_hi;  // a byte write replaces the step

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    ovf  = 1'b0;
    if (step) begin
      unique case (mode_i)
        MODE_13: begin
          if (&lo_q[LOW_W-1:0]) begin
            lo_n[LOW_W-1:0] = '0;
            hi_n = hi_q + BYTE_ONE;
            ovf  = &hi_q;
          end else begin
            lo_n[LOW_W-1:0] = lo_q[LOW_W-1:0] + LOW_ONE;
          end
        end
        MODE_16: begin
          {hi_n, lo_n} = {hi_q, lo_q} + WORD_ONE;
          ovf = &{hi_q, lo_q};
        end
        MODE_RLD: begin
          if (&lo_q) begin
            lo_n = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_n = lo_q + BYTE_ONE;
          end
        end
        default: ;
      endcase
    end
    if (wr_lo) lo_n = wr_data_i;
    if (wr_hi) hi_n = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
  assign ovf_evt_o = ovf;
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer
  import grt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int LOW_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              presc_en_i,
  input  logic              cnt_pin_i,
  input  logic              gate_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              irq_o
);
  grt_cfg_t cfg;
  logic     run, flag, inc, ovf_evt;

  grt_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ovf_evt_i (ovf_evt),
    .ack_i     (ack_i),
    .cfg_o     (cfg),
    .run_o     (run),
    .flag_o    (flag)
  );

  grt_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_pin_i  (cnt_pin_i),
    .presc_en_i (presc_en_i),
    .gate_i     (gate_i),
    .cfg_i      (cfg),
    .run_i      (run),
    .inc_o      (inc)
  );

  grt_count #(.BYTE_W(BYTE_W), .LOW_W(LOW_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mode_i    (cfg.mode),
    .inc_i     (inc),
    .lo_o      (lo_o),
    .hi_o      (hi_o),
    .ovf_evt_o (ovf_evt)
  );

  assign ovf_o = flag;
  assign irq_o = flag & cfg.irq_en;
endmodule

// File: rtl/grt_chk.sv
module grt_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic [1:0]        mode_i,
  input logic              inc_i,
  input logic              ovf_evt_i,
  input logic [BYTE_W-1:0] lo_i,
  input logic [BYTE_W-1:0] hi_i,
  input logic              ovf_i,
  input logic              irq_i
);
  assert_top_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !wr_en_i) |=> $stable(lo_i[BYTE_W-1:5]));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && inc_i && !wr_en_i && (&lo_i)) |=> (lo_i == $past(hi_i) && ovf_i));

  assert_hi_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !wr_en_i) |=> $stable(hi_i));

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_en_i) |=> ($stable(lo_i) && $stable(hi_i)));

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_i);

  assert_wr_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> (lo_i == $past(wr_data_i)));

  assert_irq_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ovf_i);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !wr_en_i) |=> ($stable(lo_i) && $stable(hi_i) && !ovf_evt_i));
endmodule

bind gated_reload_timer grt_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .mode_i    (cfg.mode),
  .inc_i     (inc),
  .ovf_evt_i (ovf_evt),
  .lo_i      (lo_o),
  .hi_i      (hi_o),
  .ovf_i     (ovf_o),
  .irq_i     (irq_o)
);

// File: tb/sim_gated_reload_timer.sv
module sim_gated_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       presc = 1'b0, pin = 1'b0, gate = 1'b0, ack = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] data = 8'd0;
  logic [7:0] lo, hi;
  logic       ovf, irq;

  gated_reload_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .presc_en_i(presc), .cnt_pin_i(pin),
    .gate_i(gate), .wr_en_i(wr_en), .wr_sel_i(sel), .wr_data_i(data),
    .ack_i(ack), .lo_o(lo), .hi_o(hi), .ovf_o(ovf), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0;
  string req = "R1";
  bit    done = 0;

  // behavioural reference state
  int m_lo, m_hi, c;
  bit m_run, m_flag, m_mode_ien, m_gpol, m_clks, m_gen, m_csel;
  int m_mode;
  bit s1, s2, s3, fall, tick, en, wl, wh, m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_run = 0; m_flag = 0; m_mode = 0;
      m_mode_ien = 0; m_gpol = 0; m_clks = 0; m_gen = 0; m_csel = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      fall = s3 && !s2;
      s3 = s2; s2 = s1; s1 = pin;
      tick = m_csel ? fall : (m_clks ? 1'b1 : presc);
      en   = m_run && (!m_gen || (gate != m_gpol)) && tick;
      wl   = wr_en && sel == 2'd0;
      wh   = wr_en && sel == 2'd1;
      m_ovf = 0;
      if (en && !wl && !wh) begin
        case (m_mode)
          0: begin
            c = m_hi * 32 + (m_lo % 32) + 1;
            if (c == 8192) begin c = 0; m_ovf = 1; end
            m_hi = c / 32;
            m_lo = (m_lo / 32) * 32 + (c % 32);
          end
          1: begin
            c = m_hi * 256 + m_lo + 1;
            if (c == 65536) begin c = 0; m_ovf = 1; end
            m_hi = c / 256;
            m_lo = c % 256;
          end
          2: begin
            if (m_lo == 255) begin m_lo = m_hi; m_ovf = 1; end
            else m_lo = m_lo + 1;
          end
          default: ;
        endcase
      end
      if (wl) m_lo = data;
      if (wh) m_hi = data;
      if (wr_en && sel == 2'd2) begin
        m_mode = data[1:0]; m_csel = data[2]; m_gen = data[3];
        m_clks = data[4]; m_gpol = data[5]; m_mode_ien = data[6];
      end
      if (wr_en && sel == 2'd3) begin
        m_run = data[4]; m_flag = data[5] || m_ovf;
      end else if (m_ovf) m_flag = 1;
      else if (ack) m_flag = 0;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, outputs are register-driven
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("lo", lo, m_lo);
      check("hi", hi, m_hi);
      check("ovf", ovf, m_flag);
      check("irq", irq, m_flag && m_mode_ien);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; sel = s; data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1";
    check("reset lo", lo, 0);
    check("reset ovf", ovf, 0);
    idle(2);

    // R3: 16-bit wrap, clock every cycle
    req = "R3";
    wr(2'd2, 8'h11);
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h10);
    idle(20);

    // R9: enable irq with flag already set
    req = "R9";
    wr(2'd2, 8'h51);
    idle(3);

    // R6: acknowledge, software set and clear of the flag
    req = "R6";
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h20);
    idle(2);
    ack = 1; @(negedge clk); ack = 0;
    idle(2);
    wr(2'd3, 8'h20);
    wr(2'd3, 8'h00);
    idle(2);

    // R2: 13-bit layout, upper low bits untouched
    req = "R2";
    wr(2'd2, 8'h10);
    wr(2'd0, 8'hFC);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h10);
    idle(12);
    wr(2'd3, 8'h10);
    wr(2'd0, 8'hA0);
    wr(2'd1, 8'h03);
    idle(40);

    // R4: reload layout
    req = "R4";
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h52);
    wr(2'd1, 8'hF8);
    wr(2'd0, 8'hFA);
    wr(2'd3, 8'h10);
    idle(30);

    // R5: gate and polarity
    req = "R5";
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h1A);
    gate = 0;
    wr(2'd3, 8'h10);
    idle(5);
    gate = 1; idle(5);
    wr(2'd2, 8'h3A);
    idle(5);
    gate = 0; idle(5);
    wr(2'd3, 8'h00);
    idle(4);
    wr(2'd2, 8'h32);   // gate disabled, polarity has no effect
    wr(2'd3, 8'h10);
    gate = 1; idle(4);

    // R7: external pin edges, then prescaled clock
    req = "R7";
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h05);
    wr(2'd0, 8'hF8);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h10);
    for (int i = 0; i < 12; i++) begin
      pin = ~pin; idle(3);
    end
    for (int i = 0; i < 20; i++) begin
      pin = ~pin; idle(1);
    end
    pin = 0;
    wr(2'd2, 8'h01);
    for (int i = 0; i < 30; i++) begin
      presc = (i % 3 == 0); idle(1);
    end
    presc = 0;
    idle(3);

    // R8: byte writes beat the step; R6 overflow beats a same-cycle clear
    req = "R8";
    wr(2'd2, 8'h52);
    wr(2'd3, 8'h10);
    idle(3);
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h33);
    idle(3);
    wr(2'd0, 8'hFF);
    req = "R6";
    wr(2'd3, 8'h10);  // overflow in this cycle, clear loses
    idle(2);
    wr(2'd0, 8'hFF);
    ack = 1; @(negedge clk); ack = 0;  // overflow beats acknowledge
    idle(2);

    // R10: hold mode
    req = "R10";
    wr(2'd2, 8'h13);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h10);
    idle(10);

    finish_run();
  end
endmodule